// File: doc/BRIEF.md
# Daisy-Chained TDM Serial Port

This block is the digital serial port of an audio codec that shares a time-division-multiplexed bus with other codecs. Each slot carries one 16-bit word, sent most significant bit first. Words go out on the serial data output and come in on the serial data input. The block launches data on the rising edge of the bit clock and samples it on the falling edge. All of its logic runs on one fast system clock, which oversamples the bit clock.

With the master input high, the block makes the bit clock and the frame sync itself. It claims its slots in the bit after each frame-sync pulse. With the master input low, it takes both clocks from the bus and waits for the time-slot token from the device before it in the chain. It claims the very next bit after that token. When it finishes its last slot, it raises its own token output so the next device can take over.

The number of slots claimed is three or six, set by a configuration bit. In the default frame mode a frame spans two sample periods, and the slot group is sent twice, back to back. Outgoing words are requested through a slot index and sampled from a parallel input. Each incoming word is presented on a parallel output with a one-cycle valid strobe and its slot index.

Top module: `tdm_chain_port`

## Requirements
- R1: Each owned slot shifts out on `sdo` the 16-bit `tx_data` word fetched for that slot, most significant bit first. The word is sampled in the cycle `tx_load` is high, and `tx_idx` names the slot. Data changes only after a rising bit-clock edge.
- R2: Within each owned slot, `sdi` is sampled on the falling bit-clock edges. After the sixteenth bit, `rx_valid` is high for exactly one system clock, with `rx_data` holding the word (first bit in bit 15) and `rx_slot` holding the slot index.
- R3: With `bus_master` high, `sclk_oe` and `fs_oe` are high and `sclk_out` has a period of 2*DIV_HALF system clocks. `fs_out` is high for one bit in every frame, and it rises while `sclk_out` is high. With `bus_master` low, both enables are low.
- R4: With `cfg_three` = 1 a slot group is 3 slots. With `cfg_three` = 0 it is 6 slots.
- R5: In slave mode, a high `tsi` during one bit makes the burst's first most significant bit appear in the next bit.
- R6: `tso` is high exactly during the last bit of the last slot of each group.
- R7: With `cfg_frs` = 0, a frame lasts 2*HALF_BITS bits and two groups are sent back to back, numbered 0 to 2N-1. With `cfg_frs` = 1, a frame lasts HALF_BITS bits and one group is sent, numbered 0 to N-1.
- R8: Outside owned slots `sdo_oe` is low and `sdo` is low.
- R9: After `rst_n` is low, `cfg_frs` = 0 and `cfg_three` = 0 take effect. The serial outputs are idle and `rx_valid` is low.
- R10: In master mode `tsi` is ignored, and a burst starts in the bit after the `fs_out` pulse. The first frame sync comes in bit HALF_BITS*2-1 (or HALF_BITS-1 with `cfg_frs` = 1), counting the first bit after reset as bit 1.
- R11: In slave mode, a frame sync seen during a burst ends the burst in the next bit, unless `tsi` was high in the same bit. In that case a new burst starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bit clock |
| rst_n | input | 1 | Active-low reset |
| bus_master | input | 1 | 1: generate bit clock and frame sync |
| cfg_wr | input | 1 | Write strobe for the two configuration bits |
| cfg_frs | input | 1 | 1: one group per frame, frame = one sample period |
| cfg_three | input | 1 | 1: three slots per group, 0: six |
| sclk_in | input | 1 | Bit clock from the bus (slave) |
| sclk_out | output | 1 | Generated bit clock |
| sclk_oe | output | 1 | Drive enable for the bit clock |
| fs_in | input | 1 | Frame sync from the bus (slave) |
| fs_out | output | 1 | Generated frame sync |
| fs_oe | output | 1 | Drive enable for the frame sync |
| tsi | input | 1 | Slot token from the previous device |
| tso | output | 1 | Slot token to the next device |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Drive enable for serial data out |
| tx_data | input | WORD_W | Word for the slot named by tx_idx |
| tx_load | output | 1 | tx_data is sampled in this cycle |
| tx_idx | output | IDX_W | Index of the slot being fetched |
| rx_valid | output | 1 | Received word strobe |
| rx_data | output | WORD_W | Received word |
| rx_slot | output | IDX_W | Slot index of the received word |

## Verification
The assertions check on every cycle the properties that hold locally. The token output only rises inside an owned slot. A receive strobe never lasts two cycles. In master mode, the frame sync and data edges follow rising bit-clock edges, and every master burst begins right after a frame-sync pulse. Other behaviour needs a counted sequence across many bits, so only the bench scenarios can show it. That covers:
- the burst length for each slot-count and frame-rate setting;
- the bit after the token in which a burst starts;
- the word contents and their order;
- a frame sync cutting a slave burst short;
- a token that is ignored in master mode.

// File: rtl/tdm_chain_port.sv
module tdm_chain_port #(
  parameter int WORD_W    = 16,
  parameter int HALF_BITS = 128,
  parameter int DIV_HALF  = 4,
  parameter int GRP_SMALL = 3,
  parameter int GRP_LARGE = 6,
  parameter int IDX_W     = $clog2(2*GRP_LARGE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_master,
  input  logic              cfg_wr,
  input  logic              cfg_frs,
  input  logic              cfg_three,
  input  logic              sclk_in,
  output logic              sclk_out,
  output logic              sclk_oe,
  input  logic              fs_in,
  output logic              fs_out,
  output logic              fs_oe,
  input  logic              tsi,
  output logic              tso,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic [WORD_W-1:0] tx_data,
  output logic              tx_load,
  output logic [IDX_W-1:0]  tx_idx,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_data,
  output logic [IDX_W-1:0]  rx_slot
);
  localparam int BC_W = $clog2(WORD_W);
  localparam int FC_W = $clog2(2*HALF_BITS) + 1;
  localparam int DV_W = $clog2(DIV_HALF + 1);

  logic frs_q, three_q;
  logic s_sclk, s_fs, s_tsi, s_sdi;
  logic [DV_W-1:0] div_q;
  logic sclk_gen, sclk_d;
  logic [FC_W-1:0] fcnt;
  logic fs_seen, tsi_seen;
  logic active, grp;
  logic [BC_W-1:0] bcnt;
  logic [IDX_W-1:0] scnt;
  logic [WORD_W-1:0] txsr;
  logic [WORD_W-2:0] rxsr;
  logic rx_valid_q;
  logic [WORD_W-1:0] rx_data_q;
  logic [IDX_W-1:0] rx_slot_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      frs_q   <= 1'b0;
      three_q <= 1'b0;
    end else if (cfg_wr) begin
      frs_q   <= cfg_frs;
      three_q <= cfg_three;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s_sclk, s_fs, s_tsi, s_sdi} <= '0;
    else        {s_sclk, s_fs, s_tsi, s_sdi} <= {sclk_in, fs_in, tsi, sdi};

  // bit clock generator (master)
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_q    <= '0;
      sclk_gen <= 1'b0;
    end else if (!bus_master) begin
      div_q    <= '0;
      sclk_gen <= 1'b0;
    end else if (div_q == DV_W'(DIV_HALF - 1)) begin
      div_q    <= '0;
      sclk_gen <= ~sclk_gen;
    end else begin
      div_q <= div_q + DV_W'(1);
    end

  wire sclk_src = bus_master ? sclk_gen : s_sclk;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_src;

  wire rise_ev = sclk_src & ~sclk_d;
  wire fall_ev = ~sclk_src & sclk_d;

  // frame counter (master)
  wire [FC_W-1:0] flen = frs_q ? FC_W'(HALF_BITS) : FC_W'(2*HALF_BITS);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) fcnt <= '0;
    else if (!bus_master) fcnt <= '0;
    else if (rise_ev) fcnt <= (fcnt >= flen - FC_W'(1)) ? '0 : fcnt + FC_W'(1);

  wire fs_gen = bus_master & (fcnt == flen - FC_W'(1));
  wire fs_src = bus_master ? fs_gen : s_fs;
  wire tsi_src = ~bus_master & s_tsi;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fs_seen  <= 1'b0;
      tsi_seen <= 1'b0;
    end else if (fall_ev) begin
      fs_seen  <= fs_src;
      tsi_seen <= tsi_src;
    end

  // slot sequencer
  wire [IDX_W-1:0] ngrp = three_q ? IDX_W'(GRP_SMALL) : IDX_W'(GRP_LARGE);
  wire last_bit   = bcnt == BC_W'(WORD_W - 1);
  wire last_slot  = scnt == ngrp - IDX_W'(1);
  wire trig_start = bus_master ? fs_seen : tsi_seen;
  wire [IDX_W-1:0] idx = grp ? scnt + ngrp : scnt;
  wire burst_done = last_slot & (grp | frs_q);

  assign tx_idx  = trig_start ? '0 : idx + IDX_W'(1);
  assign tx_load = rise_ev & (trig_start | (active & ~fs_seen & last_bit & ~burst_done));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      active <= 1'b0;
      grp    <= 1'b0;
      bcnt   <= '0;
      scnt   <= '0;
      txsr   <= '0;
    end else if (rise_ev) begin
      if (trig_start) begin
        active <= 1'b1;
        grp    <= 1'b0;
        bcnt   <= '0;
        scnt   <= '0;
      end else if (fs_seen) begin
        active <= 1'b0;
      end else if (active) begin
        bcnt <= bcnt + BC_W'(1);
        if (last_bit) begin
          bcnt <= '0;
          if (burst_done) active <= 1'b0;
          else if (last_slot) begin
            grp  <= 1'b1;
            scnt <= '0;
          end else scnt <= scnt + IDX_W'(1);
        end
      end
      if (tx_load) txsr <= tx_data;
      else         txsr <= {txsr[WORD_W-2:0], 1'b0};
    end

  // receive path
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rxsr       <= '0;
      rx_valid_q <= 1'b0;
      rx_data_q  <= '0;
      rx_slot_q  <= '0;
    end else begin
      rx_valid_q <= 1'b0;
      if (fall_ev && active) begin
        rxsr <= {rxsr[WORD_W-3:0], s_sdi};
        if (last_bit) begin
          rx_valid_q <= 1'b1;
          rx_data_q  <= {rxsr, s_sdi};
          rx_slot_q  <= idx;
        end
      end
    end

  assign sclk_out = sclk_gen;
  assign sclk_oe  = bus_master;
  assign fs_out   = fs_gen;
  assign fs_oe    = bus_master;
  assign sdo      = active & txsr[WORD_W-1];
  assign sdo_oe   = active;
  assign tso      = active & last_bit & last_slot;
  assign rx_valid = rx_valid_q;
  assign rx_data  = rx_data_q;
  assign rx_slot  = rx_slot_q;
endmodule

// File: rtl/tdm_chain_port_chk.sv
module tdm_chain_port_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_master,
  input logic sclk_out,
  input logic fs_out,
  input logic sdo,
  input logic sdo_oe,
  input logic tso,
  input logic rx_valid
);
  // R6
  tso_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tso |-> sdo_oe);

  // R2
  rx_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R3
  fs_after_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_master && $rose(fs_out)) |-> sclk_out);

  // R1
  sdo_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_master && sdo_oe && $past(sdo_oe) && !$stable(sdo)) |-> sclk_out);

  // R10
  start_at_fs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_master && $rose(sdo_oe)) |-> $past(fs_out));
endmodule

bind tdm_chain_port tdm_chain_port_chk u_chk (.*);

// File: tb/tdm_chain_port_tb.sv
module tdm_chain_port_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, bus_master = 1'b0, cfg_wr = 1'b0, cfg_frs = 1'b0, cfg_three = 1'b0;
  logic sclk_in = 1'b0, fs_in = 1'b0, tsi = 1'b0, sdi = 1'b0;
  logic sclk_out, sclk_oe, fs_out, fs_oe, tso, sdo, sdo_oe, tx_load, rx_valid;
  logic [15:0] tx_data, rx_data;
  logic [3:0] tx_idx, rx_slot;

  tdm_chain_port u_dut (.*);

  int compared = 0, mismatched = 0;
  logic [15:0] tx_seed = 16'h5A3C, rx_seed = 16'h1357;
  bit done = 0;

  function automatic logic [15:0] txw(input int i);
    return tx_seed ^ 16'(i * 16'h0F1D);
  endfunction
  function automatic logic [15:0] rxw(input int i);
    return rx_seed + 16'(i * 16'h3C07);
  endfunction

  always_comb tx_data = tx_seed ^ 16'(int'(tx_idx) * 16'h0F1D);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural model state
  bit m_act, prev_fs, prev_tsi, m_frs, m_three;
  int m_b, k_bits, sc_prev, ccount, first_rise;
  int q_slot[$];
  logic [15:0] q_data[$];

  function automatic int grp_n();
    return m_three ? 3 : 6;
  endfunction
  function automatic int burst_bits();
    return grp_n() * 16 * (m_frs ? 1 : 2);
  endfunction

  task automatic model_step(input bit master);
    bit start = master ? prev_fs : prev_tsi;
    if (start) begin m_act = 1; m_b = 0; end
    else if (prev_fs) m_act = 0;
    else if (m_act) begin
      m_b++;
      if (m_b == burst_bits()) m_act = 0;
    end
  endtask

  function automatic logic exp_sdi();
    logic [15:0] w;
    if (!m_act) return 1'b0;
    w = rxw(m_b / 16);
    return w[15 - m_b % 16];
  endfunction

  task automatic observe();
    logic [15:0] w;
    logic eb, et;
    w = txw(m_b / 16);
    eb = m_act ? w[15 - m_b % 16] : 1'b0;
    et = m_act && (m_b % 16 == 15) && ((m_b / 16) % grp_n() == grp_n() - 1);
    chk("R4 R5 R7 R8 R11 sdo_oe", sdo_oe, m_act);
    chk("R1 R8 sdo", sdo, eb);
    chk("R6 tso", tso, et);
    if (m_act && m_b % 16 == 15) begin
      q_slot.push_back(m_b / 16);
      q_data.push_back(rxw(m_b / 16));
    end
  endtask

  // R2 receive monitor
  always @(negedge clk) if (rst_n && rx_valid) begin
    if (q_slot.size() == 0) chk("R2 unexpected rx_valid", 1, 0);
    else begin
      chk("R2 rx_slot", rx_slot, q_slot.pop_front());
      chk("R2 rx_data", rx_data, q_data.pop_front());
    end
  end

  task automatic do_reset(input bit master, input bit wr, input bit frs, input bit three);
    @(negedge clk);
    rst_n = 0; bus_master = master; sclk_in = 0; fs_in = 0; tsi = 0; sdi = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R9 sdo_oe idle", sdo_oe, 0);
    chk("R9 tso idle", tso, 0);
    chk("R9 rx_valid idle", rx_valid, 0);
    chk("R3 sclk_oe", sclk_oe, master);
    chk("R3 fs_oe", fs_oe, master);
    m_frs = 0; m_three = 0;
    if (wr) begin
      cfg_frs = frs; cfg_three = three; cfg_wr = 1;
      m_frs = frs; m_three = three;
    end
    @(negedge clk); cfg_wr = 0;
    m_act = 0; prev_fs = 0; prev_tsi = 0; m_b = 0;
    k_bits = 0; sc_prev = 0; ccount = 0; first_rise = 1;
  endtask

  task automatic sbit(input bit f, input bit t);
    model_step(0);
    @(negedge clk);
    sclk_in = 1; fs_in = f; tsi = t; sdi = exp_sdi();
    repeat (3) @(negedge clk);
    observe();
    sclk_in = 0;
    repeat (3) @(negedge clk);
    prev_fs = f; prev_tsi = t;
  endtask

  task automatic mbit(input bit t);
    int flen;
    bit efs;
    forever begin
      @(negedge clk); ccount++;
      if (sclk_out && sc_prev == 0) break;
      sc_prev = sclk_out;
    end
    sc_prev = 1;
    if (!first_rise) chk("R3 sclk period", ccount, 8);
    first_rise = 0; ccount = 0;
    model_step(1);
    tsi = t; sdi = exp_sdi();
    repeat (2) @(negedge clk); ccount += 2;
    k_bits++;
    flen = m_frs ? 128 : 256;
    efs = (k_bits % flen) == flen - 1;
    chk("R3 R10 fs_out", fs_out, efs);
    chk("R3 sclk_oe", sclk_oe, 1);
    observe();
    prev_fs = efs;
  endtask

  initial begin
    // S1: slave, defaults after reset (R9): six slots, two groups (R7)
    do_reset(0, 0, 0, 0);
    sbit(1, 0); sbit(0, 0); sbit(0, 0); sbit(0, 1);
    for (int i = 0; i < 200; i++) sbit(0, 0);
    // S2: three slots, one group per frame
    tx_seed = 16'hC0DE; rx_seed = 16'h8001;
    do_reset(0, 1, 1, 1);
    sbit(1, 0); sbit(0, 0); sbit(0, 1);
    for (int i = 0; i < 60; i++) sbit(0, 0);
    // S3: three slots, two groups
    tx_seed = 16'hFFFF; rx_seed = 16'h0000;
    do_reset(0, 1, 0, 1);
    sbit(0, 1);
    for (int i = 0; i < 110; i++) sbit(0, 0);
    // S4: R11 frame sync aborts, then frame sync with token restarts
    tx_seed = 16'h0001; rx_seed = 16'hA5A5;
    do_reset(0, 1, 1, 0);
    sbit(0, 1);
    for (int i = 0; i < 20; i++) sbit(0, 0);
    sbit(1, 0);
    for (int i = 0; i < 10; i++) sbit(0, 0);
    sbit(1, 1);
    for (int i = 0; i < 105; i++) sbit(0, 0);
    // M1: master, three slots, one group, token toggling (R10)
    tx_seed = 16'h7E81; rx_seed = 16'h2468;
    do_reset(1, 1, 1, 1);
    for (int i = 0; i < 400; i++) mbit(i % 5 == 0);
    // M2: master, defaults, two groups per 256-bit frame
    tx_seed = 16'h9BDF; rx_seed = 16'h4321;
    do_reset(1, 0, 0, 0);
    for (int i = 0; i < 560; i++) mbit(i % 3 == 1);
    repeat (10) @(negedge clk);
    chk("R2 all words received", q_slot.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule